// File: doc/BRIEF.md
# Pipeline Hazard Control Unit

This block makes every hazard decision for a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback). It reads register specifiers and control bits from the three pipeline latches behind decode, the source specifiers of the instruction in decode, and a resolved-taken flag for a branch in execute. From these it chooses where each ALU operand comes from, requests a one-cycle stall for a load followed by an immediate consumer, and requests a two-slot flush when a branch predicted not taken turns out to be taken.

The unit holds no state. All outputs are functions of the current latch contents, so the surrounding pipeline samples them in the same cycle. The datapath multiplexers, register file, ALU, memories and predictor live outside it.

Top module: `hazard_ctrl`

## Requirements
- R1: When the EX/MEM producer writes (write-enable 1) a nonzero register equal to an operand source of the execute-stage instruction, that operand's select is 2'b10.
- R2: When only the MEM/WB producer writes (write-enable 1) a nonzero register equal to an operand source, that operand's select is 2'b01.
- R3: When both producers write the same nonzero source register, the select is 2'b10 (the newer write wins).
- R4: A producer whose destination is register 0 never causes forwarding; the select stays 2'b00.
- R5: The two operand selects (fwd_a for rs, fwd_b for rt) are decided independently, so one may be 2'b10 while the other is 2'b01 in the same cycle.
- R6: A producer with write-enable 0 is ignored; with no matching writing producer the select is 2'b00 (register file).
- R7: A dependency three or more instructions back (no match in either latch) gives select 2'b00; the select never takes the value 2'b11.
- R8: When the execute-stage instruction is a load (mem_read 1) whose rt is nonzero and equals the decode-stage rs or rt, pc_hold, ifid_hold and idex_bubble are all 1.
- R9: No stall is requested when the execute-stage instruction is not a load, or the load targets register 0, or neither decode source matches.
- R10: When ex_branch_taken is 1, ifid_flush and idex_flush are both 1; otherwise both are 0.
- R11: When a stall and a flush are both called for, the flush wins: pc_hold, ifid_hold and idex_bubble are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| idex_rs | input | 5 | First source register of the instruction in execute |
| idex_rt | input | 5 | Second source (and load destination) of the instruction in execute |
| idex_mem_read | input | 1 | Instruction in execute is a load |
| exmem_rd | input | 5 | Destination register held in EX/MEM |
| exmem_reg_write | input | 1 | EX/MEM instruction writes a register |
| memwb_rd | input | 5 | Destination register held in MEM/WB |
| memwb_reg_write | input | 1 | MEM/WB instruction writes a register |
| ifid_rs | input | 5 | First source of the instruction in decode |
| ifid_rt | input | 5 | Second source of the instruction in decode |
| ex_branch_taken | input | 1 | Branch in execute resolved taken |
| fwd_a | output | 2 | Operand A select: 00 register file, 10 EX/MEM, 01 MEM/WB |
| fwd_b | output | 2 | Operand B select, same encoding |
| pc_hold | output | 1 | Freeze the program counter |
| ifid_hold | output | 1 | Freeze the IF/ID latch |
| idex_bubble | output | 1 | Clear control bits entering ID/EX |
| ifid_flush | output | 1 | Squash the instruction in IF/ID |
| idex_flush | output | 1 | Squash the instruction in ID/EX |

## Verification
The hardest situation to reach is the overlap of a load-use stall with a taken branch, together with a double-writer forwarding case on the same cycle, since a running pipeline rarely lines these up. The bench sets every latch field directly per vector, so it places a load with a matching decode consumer and a taken branch in one vector, and separately sets both producers to the same register with different write-enable combinations. A sweep of all register numbers confirms the register-zero exclusion does not mask any other register.

// File: rtl/hz_pkg.sv
// Package: shared encodings for the hazard control unit.
// Assumes a register file addressed by REG_W bits with register 0 hardwired to zero.
package hz_pkg;
    typedef enum logic [1:0] {
        FWD_RF    = 2'b00,
        FWD_MEMWB = 2'b01,
        FWD_EXMEM = 2'b10
    } fwd_sel_e;
endpackage

// File: rtl/hz_fwd_sel.sv
// Module: selects the source of one ALU operand.
// Assumes the two producer latches are one and two instructions ahead;
// the nearer producer has priority and register 0 never forwards.
module hz_fwd_sel
    import hz_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] src,
    input  logic [REG_W-1:0] near_rd,
    input  logic             near_we,
    input  logic [REG_W-1:0] far_rd,
    input  logic             far_we,
    output logic [1:0]       sel
);
    localparam logic [REG_W-1:0] ZERO_REG = '0;

    logic near_hit;
    logic far_hit;

    // Match each producer latch against the operand source.
    always_comb begin
        near_hit = near_we && (near_rd != ZERO_REG) && (near_rd == src);
        far_hit  = far_we  && (far_rd  != ZERO_REG) && (far_rd  == src);
    end

    // Pick the newest matching producer, else the register file.
    always_comb begin
        if (near_hit)
            sel = FWD_EXMEM;
        else if (far_hit)
            sel = FWD_MEMWB;
        else
            sel = FWD_RF;
    end

    // R7
    always_comb begin
        sel_legal_chk: assert (sel != 2'b11) else $error("select code 11 produced");
    end

    // R4
    always_comb begin
        if (src == ZERO_REG)
            zero_no_fwd_chk: assert (sel == FWD_RF) else $error("register zero forwarded");
    end
endmodule

// File: rtl/hz_load_use.sv
// Module: detects a load in execute whose result the decode instruction needs.
// Assumes the load destination is carried in the execute-stage rt field.
module hz_load_use #(
    parameter int REG_W = 5
) (
    input  logic             ld_in_ex,
    input  logic [REG_W-1:0] ld_dst,
    input  logic [REG_W-1:0] use_rs,
    input  logic [REG_W-1:0] use_rt,
    output logic             need_stall
);
    localparam logic [REG_W-1:0] ZERO_REG = '0;

    logic dst_live;

    // A load to register 0 produces nothing to wait for.
    always_comb dst_live = ld_in_ex && (ld_dst != ZERO_REG);

    // Stall when either decode source reads the pending load result.
    always_comb need_stall = dst_live && ((ld_dst == use_rs) || (ld_dst == use_rt));

    // R9
    always_comb begin
        if (!ld_in_ex)
            no_load_no_stall_chk: assert (!need_stall) else $error("stall without load");
    end
endmodule

// File: rtl/hz_flush_arb.sv
// Module: turns the stall request and taken-branch flag into pipeline controls.
// Assumes predict-not-taken with branches resolved in execute, so two
// younger instructions are in flight; a flush overrides a stall.
module hz_flush_arb (
    input  logic stall_req,
    input  logic taken,
    output logic pc_hold,
    output logic ifid_hold,
    output logic idex_bubble,
    output logic ifid_flush,
    output logic idex_flush
);
    logic stall_ok;

    // A taken branch squashes the stalling instruction, so drop the stall.
    always_comb stall_ok = stall_req && !taken;

    // Drive freeze and bubble controls from the surviving stall.
    always_comb begin
        pc_hold     = stall_ok;
        ifid_hold   = stall_ok;
        idex_bubble = stall_ok;
    end

    // Squash both younger slots on a taken branch.
    always_comb begin
        ifid_flush = taken;
        idex_flush = taken;
    end

    // R11
    always_comb begin
        flush_over_stall_chk: assert (!(ifid_flush && (pc_hold || ifid_hold || idex_bubble)))
            else $error("stall asserted during flush");
    end

    // R8
    always_comb begin
        stall_trio_chk: assert ((pc_hold == ifid_hold) && (ifid_hold == idex_bubble))
            else $error("stall controls disagree");
    end
endmodule

// File: rtl/hazard_ctrl.sv
// Module: top of the hazard control unit for a five-stage in-order pipeline.
// Combinational: outputs follow the present latch contents in the same cycle.
// Assumes register 0 reads as zero and branches resolve in execute.
module hazard_ctrl
    import hz_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] idex_rs,
    input  logic [REG_W-1:0] idex_rt,
    input  logic             idex_mem_read,
    input  logic [REG_W-1:0] exmem_rd,
    input  logic             exmem_reg_write,
    input  logic [REG_W-1:0] memwb_rd,
    input  logic             memwb_reg_write,
    input  logic [REG_W-1:0] ifid_rs,
    input  logic [REG_W-1:0] ifid_rt,
    input  logic             ex_branch_taken,
    output logic [1:0]       fwd_a,
    output logic [1:0]       fwd_b,
    output logic             pc_hold,
    output logic             ifid_hold,
    output logic             idex_bubble,
    output logic             ifid_flush,
    output logic             idex_flush
);
    localparam int NUM_OPS = 2;

    logic [REG_W-1:0] op_src [NUM_OPS];
    logic [1:0]       op_sel [NUM_OPS];
    logic             stall_req;

    // Gather the two operand sources for the per-operand selectors.
    always_comb begin
        op_src[0] = idex_rs;
        op_src[1] = idex_rt;
    end

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
        hz_fwd_sel #(.REG_W(REG_W)) u_sel (
            .src     (op_src[g]),
            .near_rd (exmem_rd),
            .near_we (exmem_reg_write),
            .far_rd  (memwb_rd),
            .far_we  (memwb_reg_write),
            .sel     (op_sel[g])
        );
    end

    // Expose the operand selects.
    always_comb begin
        fwd_a = op_sel[0];
        fwd_b = op_sel[1];
    end

    hz_load_use #(.REG_W(REG_W)) u_lu (
        .ld_in_ex   (idex_mem_read),
        .ld_dst     (idex_rt),
        .use_rs     (ifid_rs),
        .use_rt     (ifid_rt),
        .need_stall (stall_req)
    );

    hz_flush_arb u_arb (
        .stall_req   (stall_req),
        .taken       (ex_branch_taken),
        .pc_hold     (pc_hold),
        .ifid_hold   (ifid_hold),
        .idex_bubble (idex_bubble),
        .ifid_flush  (ifid_flush),
        .idex_flush  (idex_flush)
    );

    // R10
    always_comb begin
        branch_flush_chk: assert ((ifid_flush == ex_branch_taken) && (idex_flush == ex_branch_taken))
            else $error("flush does not follow taken branch");
    end

    // R3
    always_comb begin
        if (exmem_reg_write && exmem_rd != '0 && exmem_rd == idex_rs)
            newest_wins_chk: assert (fwd_a == FWD_EXMEM) else $error("older producer won");
    end
endmodule

// File: tb/sim_hazard_ctrl.sv
module sim_hazard_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk; // 50 MHz

    logic [4:0] idex_rs, idex_rt, exmem_rd, memwb_rd, ifid_rs, ifid_rt;
    logic idex_mem_read, exmem_reg_write, memwb_reg_write, ex_branch_taken;
    logic [1:0] fwd_a, fwd_b;
    logic pc_hold, ifid_hold, idex_bubble, ifid_flush, idex_flush;

    int checks = 0;
    int errors = 0;

    hazard_ctrl u0 (.*);

    typedef struct packed {
        logic [7:0] req;
        logic [4:0] irs, irt; logic imr;
        logic [4:0] erd; logic ewe;
        logic [4:0] mrd; logic mwe;
        logic [4:0] frs, frt; logic br;
        logic [1:0] xa, xb; logic xstall, xflush;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{8'd1,  5'd3, 5'd4, 1'b0, 5'd3, 1'b1, 5'd0, 1'b0, 5'd0, 5'd0, 1'b0, 2'b10, 2'b00, 1'b0, 1'b0}, // R1
        '{8'd2,  5'd3, 5'd4, 1'b0, 5'd9, 1'b1, 5'd4, 1'b1, 5'd0, 5'd0, 1'b0, 2'b00, 2'b01, 1'b0, 1'b0}, // R2
        '{8'd3,  5'd5, 5'd5, 1'b0, 5'd5, 1'b1, 5'd5, 1'b1, 5'd0, 5'd0, 1'b0, 2'b10, 2'b10, 1'b0, 1'b0}, // R3
        '{8'd4,  5'd0, 5'd0, 1'b0, 5'd0, 1'b1, 5'd0, 1'b1, 5'd0, 5'd0, 1'b0, 2'b00, 2'b00, 1'b0, 1'b0}, // R4
        '{8'd5,  5'd6, 5'd7, 1'b0, 5'd7, 1'b1, 5'd6, 1'b1, 5'd0, 5'd0, 1'b0, 2'b01, 2'b10, 1'b0, 1'b0}, // R5
        '{8'd6,  5'd3, 5'd4, 1'b0, 5'd3, 1'b0, 5'd4, 1'b0, 5'd0, 5'd0, 1'b0, 2'b00, 2'b00, 1'b0, 1'b0}, // R6
        '{8'd6,  5'd3, 5'd3, 1'b0, 5'd3, 1'b0, 5'd3, 1'b1, 5'd0, 5'd0, 1'b0, 2'b01, 2'b01, 1'b0, 1'b0}, // R6
        '{8'd7,  5'd3, 5'd4, 1'b0, 5'd8, 1'b1, 5'd9, 1'b1, 5'd0, 5'd0, 1'b0, 2'b00, 2'b00, 1'b0, 1'b0}, // R7
        '{8'd8,  5'd1, 5'd8, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 5'd8, 5'd2, 1'b0, 2'b00, 2'b00, 1'b1, 1'b0}, // R8
        '{8'd8,  5'd1, 5'd8, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 5'd2, 5'd8, 1'b0, 2'b00, 2'b00, 1'b1, 1'b0}, // R8
        '{8'd9,  5'd1, 5'd0, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 5'd0, 5'd0, 1'b0, 2'b00, 2'b00, 1'b0, 1'b0}, // R9
        '{8'd9,  5'd1, 5'd8, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd8, 5'd8, 1'b0, 2'b00, 2'b00, 1'b0, 1'b0}, // R9
        '{8'd9,  5'd1, 5'd8, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 5'd2, 5'd3, 1'b0, 2'b00, 2'b00, 1'b0, 1'b0}, // R9
        '{8'd10, 5'd1, 5'd2, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd0, 5'd0, 1'b1, 2'b00, 2'b00, 1'b0, 1'b1}, // R10
        '{8'd11, 5'd1, 5'd8, 1'b1, 5'd1, 1'b1, 5'd0, 1'b0, 5'd8, 5'd8, 1'b1, 2'b10, 2'b00, 1'b0, 1'b1}  // R11
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        @(negedge clk);
        idex_rs = v.irs; idex_rt = v.irt; idex_mem_read = v.imr;
        exmem_rd = v.erd; exmem_reg_write = v.ewe;
        memwb_rd = v.mrd; memwb_reg_write = v.mwe;
        ifid_rs = v.frs; ifid_rt = v.frt; ex_branch_taken = v.br;
        #5;
    endtask

    initial begin
        vec_t z;
        z = '0;
        drive(z);
        rst_n = 1'b1;
        // reset state: cleared latches give no forwarding, stall or flush
        check("R7 reset fwd_a", 32'(fwd_a), 32'd0);
        check("R7 reset fwd_b", 32'(fwd_b), 32'd0);
        check("R9 reset stall", 32'({pc_hold, ifid_hold, idex_bubble}), 32'd0);
        check("R10 reset flush", 32'({ifid_flush, idex_flush}), 32'd0);

        for (int i = 0; i < NV; i++) begin
            string t;
            drive(VECS[i]);
            t = $sformatf("R%0d vec%0d", VECS[i].req, i);
            check({t, " fwd_a"}, 32'(fwd_a), 32'(VECS[i].xa));
            check({t, " fwd_b"}, 32'(fwd_b), 32'(VECS[i].xb));
            check({t, " stall"}, 32'({pc_hold, ifid_hold, idex_bubble}), VECS[i].xstall ? 32'd7 : 32'd0);
            check({t, " flush"}, 32'({ifid_flush, idex_flush}), VECS[i].xflush ? 32'd3 : 32'd0);
        end

        // R4 / R1 sweep: every register forwards from EX/MEM except register 0
        for (int r = 0; r < 32; r++) begin
            vec_t v;
            v = '0;
            v.irs = 5'(r); v.erd = 5'(r); v.ewe = 1'b1;
            drive(v);
            check(r == 0 ? "R4 sweep" : "R1 sweep", 32'(fwd_a), r == 0 ? 32'd0 : 32'd2);
        end

        // R8 / R11 corner: stall held, then branch arrives and cancels it
        begin
            vec_t v;
            v = '0;
            v.imr = 1'b1; v.irt = 5'd31; v.frt = 5'd31;
            drive(v);
            check("R8 rt31 stall", 32'({pc_hold, ifid_hold, idex_bubble}), 32'd7);
            v.br = 1'b1;
            drive(v);
            check("R11 cancel stall", 32'({pc_hold, ifid_hold, idex_bubble}), 32'd0);
            check("R10 flush", 32'({ifid_flush, idex_flush}), 32'd3);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule